// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level structure held in memory: a page directory whose base comes from a register, and a page table chosen by the directory entry. A requester presents one translation at a time with a read/write flag. The walker fetches the directory entry and then the table entry through a read port, with a request/valid handshake. It then reports either the physical address with the page's caching and user attributes, or a page fault. On a fault it latches the faulting linear address.

After a successful walk the walker updates the entries in memory through a write port, with a request/acknowledge handshake. It sets the accessed flag in both entries. On a write access it also sets the dirty flag in the table entry. When paging is switched off, the linear address passes straight through and no memory traffic occurs.

The controller has seven states:
- IDLE waits for a request.
- DIR_RD fetches the directory entry.
- TBL_RD fetches the table entry.
- DIR_WB writes back the directory entry.
- TBL_WB writes back the table entry.
- DONE is a one-cycle success pulse.
- FAULT is a one-cycle fault pulse.

The transitions are:
- IDLE→DIR_RD on a request with paging on.
- IDLE→DONE on a request with paging off.
- DIR_RD→TBL_RD when the directory entry is present.
- DIR_RD→FAULT when it is absent.
- TBL_RD→FAULT when the table entry is absent, or on a write to a read-only page.
- TBL_RD→DIR_WB, →TBL_WB or →DONE, whichever is the first update still needed.
- DIR_WB→TBL_WB or →DONE on acknowledge.
- TBL_WB→DONE on acknowledge.
- DONE→IDLE and FAULT→IDLE unconditionally.

Top module: `pt_walker`

## Requirements
- R1: With paging off at acceptance, the cycle after acceptance shows xlate_done with phys_addr equal to the linear address, all three attribute outputs at 0, and no read or write request during the transaction.
- R2: The directory entry is read at {dir_base[31:12], 12'b0} + 4*lin[31:22], and the table entry at {dir_entry[31:12], 12'b0} + 4*lin[21:12]. The low 12 bits of dir_base have no effect.
- R3: The entry layout is: bit 0 present, bit 1 writable, bit 2 user, bit 3 write-through, bit 4 cache-disable, bit 5 accessed, bit 6 dirty, bits 31:12 next-level or frame base.
- R4: On success, phys_addr = {table_entry[31:12], lin[11:0]}, with pg_wt, pg_cd and pg_user taken from table entry bits 3, 4 and 2.
- R5: A directory entry with bit 0 clear faults after exactly one read. A table entry with bit 0 clear faults after exactly two reads. Neither case issues a write.
- R6: A write access whose table entry has bit 1 clear faults after two reads and issues no write.
- R7: On success, the directory entry is written back first, with bit 5 set and bit 6 cleared, but only if that changes it. Then the table entry is written back with bit 5 set, plus bit 6 on a write access, but only if that changes it.
- R8: On a fault, fault_addr takes the linear address. It holds its value on success and is 0 after reset.
- R9: busy is high from the cycle after acceptance through the DONE or FAULT cycle. A request presented while busy is ignored. xlate_done and xlate_fault never rise together.
- R10: mem_rd_req holds with a stable address until mem_rd_valid. mem_wr_req holds with stable address and data until mem_wr_ack. Read and write requests are never high together.
- R11: After reset, busy, xlate_done, xlate_fault, mem_rd_req and mem_wr_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, accepted when not busy |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| paging_en | input | 1 | Paging enable, sampled at acceptance |
| dir_base | input | 32 | Directory base, sampled at acceptance |
| busy | output | 1 | Transaction in progress |
| mem_rd_req | output | 1 | Entry read request |
| mem_rd_addr | output | 32 | Entry read byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Entry write request |
| mem_wr_addr | output | 32 | Entry write byte address |
| mem_wr_data | output | 32 | Updated entry |
| mem_wr_ack | input | 1 | Write accepted |
| xlate_done | output | 1 | One-cycle success pulse |
| phys_addr | output | 32 | Translated address |
| pg_wt | output | 1 | Page write-through |
| pg_cd | output | 1 | Page cache-disable |
| pg_user | output | 1 | Page user flag |
| xlate_fault | output | 1 | One-cycle page fault pulse |
| fault_addr | output | 32 | Last faulting linear address |

## Verification
A wrong state in the controller shows at the memory ports within one cycle. Typical symptoms are a read to the wrong entry address, a third read after a non-present entry, or a write-back that repeats or skips a change. A corrupted captured entry shows at the very next DONE pulse as a wrong frame, wrong attribute bits or a wrong write-back value. The bench keeps a behavioural memory and works out the expected reads, writes and result from the entry contents before each request. It compares busy on every cycle and compares the result in the DONE or FAULT cycle.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_TBL_RD,
        ST_DIR_WB,
        ST_TBL_WB,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    // entry flag positions
    localparam int BIT_P  = 0;
    localparam int BIT_W  = 1;
    localparam int BIT_U  = 2;
    localparam int BIT_WT = 3;
    localparam int BIT_CD = 4;
    localparam int BIT_A  = 5;
    localparam int BIT_D  = 6;
endpackage

// File: rtl/pw_entry_eval.sv
module pw_entry_eval
    import pw_pkg::*;
#(
    parameter int AW      = 32,
    parameter bit IS_LEAF = 1'b0
) (
    input  logic [AW-1:0] entry,
    input  logic          is_write,
    output logic          present,
    output logic          perm_fault,
    output logic [AW-1:0] upd_entry,
    output logic          upd_needed
);
    assign present = entry[BIT_P];

    generate
        if (IS_LEAF) begin : g_leaf
            always_comb begin
                upd_entry        = entry;
                upd_entry[BIT_A] = 1'b1;
                if (is_write)
                    upd_entry[BIT_D] = 1'b1;
                perm_fault = is_write && !entry[BIT_W];
            end
        end else begin : g_dir
            logic unused_wr;
            assign unused_wr = is_write;
            always_comb begin
                upd_entry        = entry;
                upd_entry[BIT_A] = 1'b1;
                upd_entry[BIT_D] = 1'b0;
                perm_fault       = 1'b0;
            end
        end
    endgenerate

    assign upd_needed = (upd_entry != entry);
endmodule

// File: rtl/pw_fault_reg.sv
module pw_fault_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] lin_in,
    output logic [AW-1:0] fault_addr
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_addr <= '0;
        else if (capture)
            fault_addr <= lin_in;
    end

    AST_FAULT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(fault_addr)); // R8
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          paging_en,
    input  logic [AW-1:0] dir_base,
    output logic          busy,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [AW-1:0] mem_rd_data,
    output logic          mem_wr_req,
    output logic [AW-1:0] mem_wr_addr,
    output logic [AW-1:0] mem_wr_data,
    input  logic          mem_wr_ack,
    output logic          xlate_done,
    output logic [AW-1:0] phys_addr,
    output logic          pg_wt,
    output logic          pg_cd,
    output logic          pg_user,
    output logic          xlate_fault,
    output logic [AW-1:0] fault_addr
);
    localparam int PG_W      = AW - OFF_W;
    localparam int ENT_SHIFT = 2;

    walk_state_t state_q, state_d;

    logic [AW-1:0]   lin_q;
    logic            wr_q;
    logic [PG_W-1:0] base_q;
    logic [PG_W-1:0] pde_page_q;
    logic [AW-1:0]   pde_upd_q, pte_upd_q;
    logic            pde_need_q, pte_need_q;
    logic [AW-1:0]   pa_q;
    logic [2:0]      flags_q;   // {user, cd, wt}

    logic [AW-1:0] dir_addr, tbl_addr;
    logic          dir_present, dir_pf, dir_need;
    logic [AW-1:0] dir_upd;
    logic          leaf_present, leaf_pf, leaf_need;
    logic [AW-1:0] leaf_upd;
    logic          leaf_bad, fault_capture, accept;

    // entry address generation
    always_comb begin
        dir_addr = {base_q, {OFF_W{1'b0}}}
                 + (AW'(lin_q[AW-1 -: IDX_W]) << ENT_SHIFT);
        tbl_addr = {pde_page_q, {OFF_W{1'b0}}}
                 + (AW'(lin_q[OFF_W +: IDX_W]) << ENT_SHIFT);
    end

    pw_entry_eval #(.AW(AW), .IS_LEAF(1'b0)) u_dir_eval (
        .entry      (mem_rd_data),
        .is_write   (wr_q),
        .present    (dir_present),
        .perm_fault (dir_pf),
        .upd_entry  (dir_upd),
        .upd_needed (dir_need)
    );

    pw_entry_eval #(.AW(AW), .IS_LEAF(1'b1)) u_leaf_eval (
        .entry      (mem_rd_data),
        .is_write   (wr_q),
        .present    (leaf_present),
        .perm_fault (leaf_pf),
        .upd_entry  (leaf_upd),
        .upd_needed (leaf_need)
    );

    assign accept        = (state_q == ST_IDLE) && req_valid;
    assign leaf_bad      = !leaf_present || leaf_pf;
    assign fault_capture = mem_rd_valid &&
                           (((state_q == ST_DIR_RD) && (!dir_present || dir_pf)) ||
                            ((state_q == ST_TBL_RD) && leaf_bad));

    pw_fault_reg #(.AW(AW)) u_fault_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (fault_capture),
        .lin_in     (lin_q),
        .fault_addr (fault_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (req_valid)
                    state_d = paging_en ? ST_DIR_RD : ST_DONE;
            ST_DIR_RD:
                if (mem_rd_valid)
                    state_d = dir_present ? ST_TBL_RD : ST_FAULT;
            ST_TBL_RD:
                if (mem_rd_valid) begin
                    if (leaf_bad)        state_d = ST_FAULT;
                    else if (pde_need_q) state_d = ST_DIR_WB;
                    else if (leaf_need)  state_d = ST_TBL_WB;
                    else                 state_d = ST_DONE;
                end
            ST_DIR_WB:
                if (mem_wr_ack)
                    state_d = pte_need_q ? ST_TBL_WB : ST_DONE;
            ST_TBL_WB:
                if (mem_wr_ack)
                    state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lin_q      <= '0;
            wr_q       <= 1'b0;
            base_q     <= '0;
            pde_page_q <= '0;
            pde_upd_q  <= '0;
            pte_upd_q  <= '0;
            pde_need_q <= 1'b0;
            pte_need_q <= 1'b0;
            pa_q       <= '0;
            flags_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                lin_q  <= req_addr;
                wr_q   <= req_write;
                base_q <= dir_base[AW-1:OFF_W];
                if (!paging_en) begin
                    pa_q    <= req_addr;
                    flags_q <= '0;
                end
            end
            if ((state_q == ST_DIR_RD) && mem_rd_valid) begin
                pde_page_q <= mem_rd_data[AW-1:OFF_W];
                pde_upd_q  <= dir_upd;
                pde_need_q <= dir_need;
            end
            if ((state_q == ST_TBL_RD) && mem_rd_valid) begin
                pte_upd_q  <= leaf_upd;
                pte_need_q <= leaf_need;
                pa_q       <= {mem_rd_data[AW-1:OFF_W], lin_q[OFF_W-1:0]};
                flags_q    <= {mem_rd_data[BIT_U], mem_rd_data[BIT_CD],
                               mem_rd_data[BIT_WT]};
            end
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        mem_rd_req  = (state_q == ST_DIR_RD) || (state_q == ST_TBL_RD);
        mem_rd_addr = (state_q == ST_TBL_RD) ? tbl_addr : dir_addr;
        mem_wr_req  = (state_q == ST_DIR_WB) || (state_q == ST_TBL_WB);
        mem_wr_addr = (state_q == ST_TBL_WB) ? tbl_addr : dir_addr;
        mem_wr_data = (state_q == ST_TBL_WB) ? pte_upd_q : pde_upd_q;
        xlate_done  = (state_q == ST_DONE);
        xlate_fault = (state_q == ST_FAULT);
        phys_addr   = pa_q;
        pg_user     = flags_q[2];
        pg_cd       = flags_q[1];
        pg_wt       = flags_q[0];
    end

    AST_OFF_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !paging_en) |=> (xlate_done && !mem_rd_req && !mem_wr_req)); // R1
    AST_DIR_ABSENT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DIR_RD) && mem_rd_valid && !mem_rd_data[BIT_P])
        |=> (xlate_fault && !mem_rd_req)); // R5
    AST_DIR_WB_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIR_WB) |-> (mem_wr_data[BIT_A] && !mem_wr_data[BIT_D])); // R7
    AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(xlate_done && xlate_fault)); // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R10
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack)
        |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R10
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R10
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        paging_en = 1'b0;
    logic [31:0] dir_base = '0;
    logic        busy, mem_rd_req, mem_wr_req, xlate_done, xlate_fault;
    logic        pg_wt, pg_cd, pg_user;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data, phys_addr, fault_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_ack = 1'b0;

    always #2 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .paging_en(paging_en), .dir_base(dir_base),
        .busy(busy), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
        .xlate_done(xlate_done), .phys_addr(phys_addr), .pg_wt(pg_wt),
        .pg_cd(pg_cd), .pg_user(pg_user), .xlate_fault(xlate_fault),
        .fault_addr(fault_addr)
    );

    logic [31:0] mem [logic [31:0]];
    logic [63:0] wr_log [$];
    int          rd_count = 0;
    int          lat = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [31:0] last_fault = '0;

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural memory: answers after lat idle cycles
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rd_valid || mem_wr_ack) begin
                mem_rd_valid = 1'b0;
                mem_wr_ack   = 1'b0;
                wait_cnt     = 0;
            end else if (mem_rd_req || mem_wr_req) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    if (mem_rd_req) begin
                        mem_rd_data  = mrd(mem_rd_addr);
                        mem_rd_valid = 1'b1;
                        rd_count++;
                    end else begin
                        mem[mem_wr_addr] = mem_wr_data;
                        wr_log.push_back({mem_wr_addr, mem_wr_data});
                        mem_wr_ack = 1'b1;
                    end
                end else
                    wait_cnt++;
            end
        end
    end

    // reference: expected result from the entry contents (R2..R7)
    task automatic ref_walk(input logic [31:0] lin, input bit wr, input bit en,
                            input logic [31:0] base, output bit e_fault,
                            output logic [31:0] e_pa, output logic [2:0] e_flags,
                            output int e_reads, ref logic [63:0] e_wr[$]);
        logic [31:0] pa_d, pde, pt_a, pte, nd, np;
        e_wr.delete();
        e_fault = 0; e_pa = lin; e_flags = 3'b000; e_reads = 0;
        if (!en) return;
        pa_d = {base[31:12], 12'h0} + {20'h0, lin[31:22], 2'b00};
        pde  = mrd(pa_d); e_reads = 1;
        if (!pde[0]) begin e_fault = 1; return; end
        pt_a = {pde[31:12], 12'h0} + {20'h0, lin[21:12], 2'b00};
        pte  = mrd(pt_a); e_reads = 2;
        if (!pte[0] || (wr && !pte[1])) begin e_fault = 1; return; end
        e_pa    = {pte[31:12], lin[11:0]};
        e_flags = {pte[2], pte[4], pte[3]};
        nd = (pde | 32'h20) & ~32'h40;
        if (nd != pde) e_wr.push_back({pa_d, nd});
        np = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (np != pte) e_wr.push_back({pt_a, np});
    endtask

    task automatic do_req(input string tag, input logic [31:0] lin, input bit wr,
                          input bit en, input bit poke);
        bit          e_fault, got;
        logic [31:0] e_pa;
        logic [2:0]  e_flags;
        int          e_reads, bad_busy, cyc;
        logic [63:0] e_wr [$];
        ref_walk(lin, wr, en, dir_base, e_fault, e_pa, e_flags, e_reads, e_wr);
        @(negedge clk);
        wr_log.delete(); rd_count = 0;
        req_valid = 1; req_addr = lin; req_write = wr; paging_en = en;
        got = 0; cyc = 0; bad_busy = 0;
        while (!got && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) req_valid = 0;
            if (poke && cyc == 2) begin req_valid = 1; req_addr = 32'h0080_0000; end
            if (poke && cyc == 3) req_valid = 0;
            if (en == 0 && cyc == 1 && !xlate_done)
                check({tag, " R1 done next cycle"}, {31'h0, xlate_done}, 32'h1);
            if (xlate_done || xlate_fault) got = 1;
            else if (!busy || mem_rd_req && mem_wr_req) bad_busy++;
        end
        req_valid = 0;
        check({tag, " R9 busy held / R10 no overlap"}, bad_busy, 0);
        check({tag, " R5/R6 fault flag"}, {31'h0, xlate_fault}, {31'h0, e_fault});
        check({tag, " R9 done excl"}, {31'h0, xlate_done & xlate_fault}, 32'h0);
        check({tag, " R2/R5 read count"}, rd_count, e_reads);
        if (e_fault) begin
            last_fault = lin;
            check({tag, " R8 fault_addr"}, fault_addr, lin);
        end else begin
            check({tag, " R4 phys_addr"}, phys_addr, e_pa);
            check({tag, " R4 attr"}, {29'h0, pg_user, pg_cd, pg_wt}, {29'h0, e_flags});
            check({tag, " R8 fault_addr held"}, fault_addr, last_fault);
        end
        check({tag, " R7 write count"}, wr_log.size(), e_wr.size());
        for (int i = 0; i < e_wr.size() && i < wr_log.size(); i++) begin
            check({tag, " R7 write addr"}, wr_log[i][63:32], e_wr[i][63:32]);
            check({tag, " R7 write data"}, wr_log[i][31:0], e_wr[i][31:0]);
        end
        @(negedge clk);
        check({tag, " R9 idle after end"}, {31'h0, busy}, 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        check("R11 busy", {31'h0, busy}, 32'h0);
        check("R11 done/fault", {30'h0, xlate_done, xlate_fault}, 32'h0);
        check("R11 mem req", {30'h0, mem_rd_req, mem_wr_req}, 32'h0);
        check("R11 R8 fault_addr", fault_addr, 32'h0);
        rst_n = 1;
        @(negedge clk);

        // tables; low bits of dir_base must be ignored (R2)
        dir_base = 32'h0001_0ABC;
        mem[32'h0001_0030] = 32'h0002_0007;   // dir idx 0x00C: P W U
        mem[32'h0002_0040] = 32'h0500_100B;   // tbl idx 0x010: P W WT
        mem[32'h0001_0004] = 32'h0003_0061;   // dir idx 1: P A D (D must clear)
        mem[32'h0003_0000] = 32'h0ABC_D035;   // tbl idx 0: P U CD A, read-only

        do_req("off-read R1",  32'h0301_008A, 0, 0, 0);
        do_req("off-write R1", 32'hFFFF_F123, 1, 0, 0);
        do_req("walk-read R2 R3 R7", 32'h0301_008A, 0, 1, 0);
        do_req("walk-reread R7", 32'h0301_008A, 0, 1, 0);
        do_req("walk-write R7", 32'h0301_0FFF, 1, 1, 0);
        do_req("walk-rewrite R7", 32'h0301_0000, 1, 1, 0);
        do_req("dir-dirty R7 R4", 32'h0040_0123, 0, 1, 0);
        do_req("ro-write R6", 32'h0040_0456, 1, 1, 0);
        do_req("dir-absent R5", 32'h0080_0000, 0, 1, 0);
        do_req("after-fault R8", 32'h0040_0777, 0, 1, 0);
        do_req("tbl-absent R5", 32'h0040_1000, 1, 1, 0);
        lat = 3;
        mem[32'h0002_0044] = 32'h1234_5019;   // tbl idx 0x011: P WT CD
        do_req("slow-mem R10", 32'h0301_1ABC, 0, 1, 0);
        do_req("busy-ignore R9", 32'h0301_1ABC, 0, 1, 1);
        lat = 1;
        dir_base = 32'h0001_0FFF;
        do_req("base-low R2", 32'h0301_1001, 0, 1, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule